// File: doc/BRIEF.md
# Random Word Output Buffer

This block sits on the read side of a random number generator peripheral. A generate request from software, or an automatic refill, makes eight 32-bit random words available. Software collects them one at a time by reading a data register. Each successful read pulls one word from the generator core through a pop strobe. A 3-bit availability field in the status register tells software how many words it can still take. The field never shows more than four, even though each generate supplies eight.

In continuous mode the block asks for a fresh generate as soon as a read leaves three or fewer words. The block also keeps a reseed budget. Each generate consumes one unit of the budget. When a generate arrives with the budget exhausted, the block reseeds first and raises a sticky error flag.

Reads that cannot be served return a fixed marker word. The control register is masked according to the hardware revision parameter. Any bus access that is not a full 32-bit access is refused with an error response.

Top module: `rng_outbuf`

## Requirements
- R1: A generate sets the remaining word count to 8 and the availability field (STATUS at 0x00, bits 11:9) to 4, and pulses `gen_evt` in the following cycle.
- R2: A read of DATA (0x14) with words remaining and no reset active asserts `src_pop` and returns `src_word` in the same cycle, then decrements the count. The availability field follows the count only once the count is below 4.
- R3: A read of DATA while HOLD (0x18, bit 0) is set, or while CTRL bit 0 is set, or while no words remain, returns 0x00000BAD, leaves `src_pop` low and leaves the count unchanged.
- R4: With CTRL bit 9 (single mode) clear and CTRL bit 5 (start) set, a DATA read that leaves 3 or fewer words triggers a generate.
- R5: A CTRL (0x04) write with start (bit 5) and generate mode (bit 7) both set performs a generate and sets STATUS bit 0 (done). A CTRL write with start set and bit 7 clear reseeds: the count drops to 0, the budget is restored, done is set and `reseed_evt` pulses. Writing STATUS with bit 0 set clears done.
- R6: Every generate consumes one unit of the reseed budget, which is 0 after reset. A generate that finds the budget at 0 first reseeds, which pulses `reseed_evt` and sets FLAGS (0x1C) bit 1. Writing 1 to FLAGS bit 1 clears that bit.
- R7: Writing CTRL with bit 0 set while HOLD is clear, or writing HOLD bit 0 from 0 to 1, clears the count and the whole status register. While HOLD is set, CTRL writes are stored but start no action.
- R8: On revisions below 0x0200, writes to CFG2 (0x08), CFG3 (0x0C) and CFG4 (0x10) are dropped, and CTRL bits 10 and 9 are stored as 0. On later revisions, CTRL bits 4 and 1 are stored as 0.
- R9: After reset, CTRL reads 0, CFG2 reads 0x210C, CFG3 reads 0x26F09, HOLD reads 1, STATUS reads 0, and the output events are low.
- R10: An access with `bus_size` other than 2 (word) asserts `bus_err`, reads 0 and changes no register. If ERRCTL (0x20) bit 0 is set, it also sets FLAGS bit 0, which is cleared by writing 1 to that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size code: 0 byte, 1 half, 2 word |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| bus_err | output | 1 | Error response for an unsupported size |
| src_pop | output | 1 | Consumes the word offered by the generator core |
| src_word | input | 32 | Current word from the generator core |
| gen_evt | output | 1 | One-cycle pulse after each generate |
| reseed_evt | output | 1 | One-cycle pulse after each reseed |

## Verification
`bus_rdata`, `bus_err` and `src_pop` are combinational. They are due in the same cycle as the access. Register and count updates take effect at the next rising edge, so they show up on the next access. `gen_evt` and `reseed_evt` come from a register and are due exactly one cycle after the access that caused them.

Every bench step drives the bus at the falling edge and compares all outputs one time unit later. It uses a behavioural model that was updated at the end of the previous step. This means each result is checked in precisely the cycle in which it becomes due. A second instance built with an old revision is read back in the revision-masking steps.

// File: rtl/rng_outbuf_pkg.sv
package rng_outbuf_pkg;
    // Register byte addresses
    localparam logic [7:0] A_STAT = 8'h00;
    localparam logic [7:0] A_CTRL = 8'h04;
    localparam logic [7:0] A_CFG2 = 8'h08;
    localparam logic [7:0] A_CFG3 = 8'h0C;
    localparam logic [7:0] A_CFG4 = 8'h10;
    localparam logic [7:0] A_DATA = 8'h14;
    localparam logic [7:0] A_HOLD = 8'h18;
    localparam logic [7:0] A_FLAG = 8'h1C;
    localparam logic [7:0] A_ERRC = 8'h20;

    // Control bit positions
    localparam int C_SRST    = 0;
    localparam int C_HTEST   = 1;
    localparam int C_AUTOEAT = 4;
    localparam int C_START   = 5;
    localparam int C_GENMODE = 7;
    localparam int C_SINGLE  = 9;
    localparam int C_NOPERS  = 10;

    localparam logic [31:0] ERR_WORD = 32'h0000_0BAD;
    localparam logic [31:0] CFG2_RST = 32'h0000_210C;
    localparam logic [31:0] CFG3_RST = 32'h0002_6F09;

    localparam int WORDS_PER_GEN = 8;
    localparam int QCNT_CAP      = 4;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;
endpackage

// File: rtl/rng_outbuf_queue.sv
// Word queue bookkeeping: holds the remaining word count, the capped
// availability field, the done flag, the reseed budget and the budget error.
// Assumes at most one command or read per cycle, as the bus serialises them.
module rng_outbuf_queue
    import rng_outbuf_pkg::*;
#(
    parameter longint unsigned RESEED_LIMIT = 64'd1 << 48
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       soft_rst,
    input  logic       gen_cmd,
    input  logic       reseed_cmd,
    input  logic       rd_req,
    input  logic       in_reset,
    input  logic       auto_en,
    input  logic       done_clr,
    input  logic       rserr_clr,
    output logic [2:0] qcnt,
    output logic       done,
    output logic       rserr,
    output logic       pop,
    output logic       gen_evt,
    output logic       reseed_evt
);
    localparam int BW = $clog2(RESEED_LIMIT + 1);
    localparam int CW = $clog2(WORDS_PER_GEN + 1);

    logic [CW-1:0] cnt_q;
    logic [2:0]    qcnt_q;
    logic          done_q, rserr_q, gen_evt_q, rs_evt_q;
    logic [BW-1:0] budget_q;
    logic          rd_good, refill, do_gen, budget_empty, auto_rs;
    logic [CW-1:0] cnt_left;

    // Decide whether a read is served and whether a generate happens now
    always_comb begin
        rd_good      = rd_req && !in_reset && (cnt_q != '0);
        cnt_left     = cnt_q - CW'(1);
        refill       = rd_good && auto_en && (cnt_left <= CW'(3));
        do_gen       = !soft_rst && (gen_cmd || refill);
        budget_empty = (budget_q == '0);
        auto_rs      = do_gen && budget_empty;
    end

    // Queue state, budget and event registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            qcnt_q    <= '0;
            done_q    <= 1'b0;
            rserr_q   <= 1'b0;
            budget_q  <= '0;
            gen_evt_q <= 1'b0;
            rs_evt_q  <= 1'b0;
        end else begin
            gen_evt_q <= do_gen;
            rs_evt_q  <= (reseed_cmd && !soft_rst) || auto_rs;
            if (done_clr)  done_q  <= 1'b0;
            if (rserr_clr) rserr_q <= 1'b0;
            if (soft_rst) begin
                cnt_q  <= '0;
                qcnt_q <= '0;
                done_q <= 1'b0;
            end else if (do_gen) begin
                cnt_q    <= CW'(WORDS_PER_GEN);
                qcnt_q   <= 3'(QCNT_CAP);
                budget_q <= budget_empty ? BW'(RESEED_LIMIT - 1) : budget_q - BW'(1);
                if (auto_rs) rserr_q <= 1'b1;
                if (gen_cmd) done_q  <= 1'b1;
            end else if (reseed_cmd) begin
                cnt_q    <= '0;
                budget_q <= BW'(RESEED_LIMIT);
                done_q   <= 1'b1;
            end else if (rd_good) begin
                cnt_q <= cnt_left;
                if (cnt_left < CW'(QCNT_CAP)) qcnt_q <= 3'(cnt_left);
            end
        end
    end

    assign qcnt       = qcnt_q;
    assign done       = done_q;
    assign rserr      = rserr_q;
    assign pop        = rd_good;
    assign gen_evt    = gen_evt_q;
    assign reseed_evt = rs_evt_q;

    p_gen_fill_r1: assert property (@(posedge clk) disable iff (!rst_n)
        do_gen |=> (cnt_q == CW'(WORDS_PER_GEN)) && (qcnt_q == 3'(QCNT_CAP)) && gen_evt_q);
    p_read_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_good && !refill && !soft_rst) |=> cnt_q == CW'($past(cnt_q) - CW'(1)));
    p_bad_read_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_good && !soft_rst && !gen_cmd && !reseed_cmd) |=> $stable(cnt_q));
    p_budget_auto_r6: assert property (@(posedge clk) disable iff (!rst_n)
        auto_rs |=> rserr_q && rs_evt_q);
    p_soft_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (cnt_q == '0) && (qcnt_q == '0) && !done_q);
endmodule

// File: rtl/rng_outbuf_regs.sv
// Software-visible configuration registers with revision-dependent write
// masking. Assumes wr_en is already qualified by a valid word-size access.
module rng_outbuf_regs
    import rng_outbuf_pkg::*;
#(
    parameter logic [15:0] HW_REV = 16'h0200
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  addr,
    input  logic [31:0] wdata,
    input  logic        slv_set,
    output logic [31:0] ctrl_wval,
    output logic [31:0] ctrl_q,
    output logic [31:0] cfg2_q,
    output logic [31:0] cfg3_q,
    output logic [31:0] cfg4_q,
    output logic        hold_q,
    output logic        errc_q,
    output logic        slv_q
);
    localparam bit OLD_REV = (HW_REV < 16'h0200);
    localparam logic [31:0] CTRL_KEEP = OLD_REV ?
        ~((32'd1 << C_SINGLE) | (32'd1 << C_NOPERS)) :
        ~((32'd1 << C_AUTOEAT) | (32'd1 << C_HTEST));

    logic cfg_wr_allow;

    generate
        if (OLD_REV) begin : g_old_rev
            assign cfg_wr_allow = 1'b0;
        end else begin : g_new_rev
            assign cfg_wr_allow = 1'b1;
        end
    endgenerate

    // Masked control value as it will be stored
    assign ctrl_wval = wdata & CTRL_KEEP;

    // Register file update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            cfg2_q <= CFG2_RST;
            cfg3_q <= CFG3_RST;
            cfg4_q <= '0;
            hold_q <= 1'b1;
            errc_q <= 1'b0;
            slv_q  <= 1'b0;
        end else begin
            if (wr_en) begin
                case (addr)
                    A_CTRL: ctrl_q <= ctrl_wval;
                    A_CFG2: if (cfg_wr_allow) cfg2_q <= wdata;
                    A_CFG3: if (cfg_wr_allow) cfg3_q <= wdata;
                    A_CFG4: if (cfg_wr_allow) cfg4_q <= wdata;
                    A_HOLD: hold_q <= wdata[0];
                    A_ERRC: errc_q <= wdata[0];
                    A_FLAG: if (wdata[0]) slv_q <= 1'b0;
                    default: ;
                endcase
            end
            if (slv_set) slv_q <= 1'b1;
        end
    end

    generate
        if (OLD_REV) begin : g_chk_old
            p_cfg_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && addr == A_CFG2) |=> $stable(cfg2_q));
        end else begin : g_chk_new
            p_cfg_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && addr == A_CFG2) |=> cfg2_q == $past(wdata));
        end
    endgenerate

    p_slv_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        slv_set |=> slv_q);
endmodule

// File: rtl/rng_outbuf.sv
// Output word buffer top: decodes the 32-bit register bus, turns control
// writes into generate, reseed and soft-reset commands, and muxes read data.
// Assumes one bus access per cycle with a same-cycle combinational response.
module rng_outbuf
    import rng_outbuf_pkg::*;
#(
    parameter logic [15:0]     HW_REV       = 16'h0200,
    parameter longint unsigned RESEED_LIMIT = 64'd1 << 48
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [1:0]  bus_size,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        bus_err,
    output logic        src_pop,
    input  logic [31:0] src_word,
    output logic        gen_evt,
    output logic        reseed_evt
);
    logic        size_ok, wr_en, rd_en, ctrl_wr, in_reset;
    logic        soft_rst, cmd_ok, gen_cmd, reseed_cmd, auto_en, rd_data;
    logic        done_clr, rserr_clr, slv_set;
    logic [31:0] ctrl_wval, ctrl_q, cfg2_q, cfg3_q, cfg4_q;
    logic        hold_q, errc_q, slv_q, done, rserr;
    logic [2:0]  qcnt;

    // Access qualification and command decode
    always_comb begin
        size_ok    = (bus_size == SZ_WORD);
        wr_en      = bus_sel && size_ok && bus_wr;
        rd_en      = bus_sel && size_ok && !bus_wr;
        bus_err    = bus_sel && !size_ok;
        slv_set    = bus_err && errc_q;
        in_reset   = hold_q || ctrl_q[C_SRST];
        ctrl_wr    = wr_en && (bus_addr == A_CTRL);
        soft_rst   = (ctrl_wr && !hold_q && ctrl_wval[C_SRST]) ||
                     (wr_en && (bus_addr == A_HOLD) && bus_wdata[0] && !hold_q);
        cmd_ok     = ctrl_wr && !hold_q && !ctrl_wval[C_SRST] && ctrl_wval[C_START];
        gen_cmd    = cmd_ok && ctrl_wval[C_GENMODE];
        reseed_cmd = cmd_ok && !ctrl_wval[C_GENMODE];
        auto_en    = !ctrl_q[C_SINGLE] && ctrl_q[C_START];
        rd_data    = rd_en && (bus_addr == A_DATA);
        done_clr   = wr_en && (bus_addr == A_STAT) && bus_wdata[0];
        rserr_clr  = wr_en && (bus_addr == A_FLAG) && bus_wdata[1];
    end

    rng_outbuf_regs #(.HW_REV(HW_REV)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .slv_set   (slv_set),
        .ctrl_wval (ctrl_wval),
        .ctrl_q    (ctrl_q),
        .cfg2_q    (cfg2_q),
        .cfg3_q    (cfg3_q),
        .cfg4_q    (cfg4_q),
        .hold_q    (hold_q),
        .errc_q    (errc_q),
        .slv_q     (slv_q)
    );

    rng_outbuf_queue #(.RESEED_LIMIT(RESEED_LIMIT)) queue_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .gen_cmd    (gen_cmd),
        .reseed_cmd (reseed_cmd),
        .rd_req     (rd_data),
        .in_reset   (in_reset),
        .auto_en    (auto_en),
        .done_clr   (done_clr),
        .rserr_clr  (rserr_clr),
        .qcnt       (qcnt),
        .done       (done),
        .rserr      (rserr),
        .pop        (src_pop),
        .gen_evt    (gen_evt),
        .reseed_evt (reseed_evt)
    );

    // Read data multiplexer
    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            case (bus_addr)
                A_STAT: bus_rdata = {20'd0, qcnt, 8'd0, done};
                A_CTRL: bus_rdata = ctrl_q;
                A_CFG2: bus_rdata = cfg2_q;
                A_CFG3: bus_rdata = cfg3_q;
                A_CFG4: bus_rdata = cfg4_q;
                A_DATA: bus_rdata = src_pop ? src_word : ERR_WORD;
                A_HOLD: bus_rdata = {31'd0, hold_q};
                A_FLAG: bus_rdata = {30'd0, rserr, slv_q};
                A_ERRC: bus_rdata = {31'd0, errc_q};
                default: bus_rdata = '0;
            endcase
        end
    end

    p_bad_size_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !size_ok) |=> $stable(ctrl_q) && $stable(hold_q) && $stable(cfg2_q));
    p_err_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && in_reset) |-> (bus_rdata == ERR_WORD) && !src_pop);
endmodule

// File: tb/rng_outbuf_tb_top.sv
module rng_outbuf_tb_top;
    import rng_outbuf_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam longint unsigned LIM = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0]  bus_size = 2'd2;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, old_rdata;
    logic        bus_err, src_pop, gen_evt, reseed_evt;
    logic        old_err, old_pop, old_gen, old_rs;
    logic [31:0] lfsr = 32'hACE1_2345;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Generator core stub: advances on every pop
    always @(posedge clk) if (src_pop) lfsr <= {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};

    rng_outbuf #(.HW_REV(16'h0200), .RESEED_LIMIT(LIM)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_size(bus_size),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .src_pop(src_pop), .src_word(lfsr), .gen_evt(gen_evt), .reseed_evt(reseed_evt));

    rng_outbuf #(.HW_REV(16'h0100), .RESEED_LIMIT(LIM)) dut_old (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_size(bus_size),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(old_rdata), .bus_err(old_err),
        .src_pop(old_pop), .src_word(32'h0), .gen_evt(old_gen), .reseed_evt(old_rs));

    int total = 0, bad = 0;
    // Behavioural model state
    int m_cnt = 0, m_qcnt = 0;
    longint m_budget = 0;
    bit m_done = 0, m_rserr = 0, m_slv = 0, m_hold = 1, m_errc = 0;
    logic [31:0] m_ctrl = 0, m_cfg2 = 32'h210C, m_cfg3 = 32'h26F09, m_cfg4 = 0;
    bit e_gen = 0, e_rs = 0, n_gen = 0, n_rs = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic m_generate();
        if (m_budget == 0) begin
            m_budget = LIM;
            m_rserr = 1;
            n_rs = 1;
        end
        m_budget--;
        m_cnt = 8;
        m_qcnt = 4;
        n_gen = 1;
    endtask

    task automatic m_soft();
        m_cnt = 0;
        m_qcnt = 0;
        m_done = 0;
    endtask

    function automatic logic [31:0] m_read(input logic [7:0] a, input bit good);
        case (a)
            A_STAT: return {20'd0, 3'(m_qcnt), 8'd0, m_done};
            A_CTRL: return m_ctrl;
            A_CFG2: return m_cfg2;
            A_CFG3: return m_cfg3;
            A_CFG4: return m_cfg4;
            A_DATA: return good ? lfsr : 32'h0000_0BAD;
            A_HOLD: return {31'd0, m_hold};
            A_FLAG: return {30'd0, m_rserr, m_slv};
            A_ERRC: return {31'd0, m_errc};
            default: return 32'd0;
        endcase
    endfunction

    // One bus cycle: drive at the falling edge, compare, then advance the model
    task automatic step(input string tag, input bit sel, input bit wr, input logic [1:0] sz,
                        input logic [7:0] a, input logic [31:0] d,
                        input bit chk_old = 0, input logic [31:0] old_exp = 0);
        bit ok, good;
        logic [31:0] exp_rd, v;
        @(negedge clk);
        bus_sel = sel; bus_wr = wr; bus_size = sz; bus_addr = a; bus_wdata = d;
        #1;
        ok = sel && (sz == 2'd2);
        good = ok && !wr && (a == A_DATA) && !m_hold && !m_ctrl[0] && (m_cnt != 0);
        exp_rd = (ok && !wr) ? m_read(a, good) : 32'd0;
        chk({tag, " rdata"}, bus_rdata, exp_rd);
        chk("R10 bus_err", {31'd0, bus_err}, {31'd0, sel && !ok});
        chk("R2 src_pop", {31'd0, src_pop}, {31'd0, good});
        chk("R1 gen_evt", {31'd0, gen_evt}, {31'd0, e_gen});
        chk("R6 reseed_evt", {31'd0, reseed_evt}, {31'd0, e_rs});
        if (chk_old) chk("R8 old revision rdata", old_rdata, old_exp);
        n_gen = 0; n_rs = 0;
        if (sel && !ok && m_errc) m_slv = 1;
        if (ok && wr) begin
            case (a)
                A_CTRL: begin
                    v = d & ~32'h12;
                    m_ctrl = v;
                    if (!m_hold) begin
                        if (v[0]) m_soft();
                        else if (v[5]) begin
                            if (v[7]) m_generate();
                            else begin m_cnt = 0; m_budget = LIM; n_rs = 1; end
                            m_done = 1;
                        end
                    end
                end
                A_STAT: if (d[0]) m_done = 0;
                A_CFG2: m_cfg2 = d;
                A_CFG3: m_cfg3 = d;
                A_CFG4: m_cfg4 = d;
                A_HOLD: begin if (d[0] && !m_hold) m_soft(); m_hold = d[0]; end
                A_FLAG: begin if (d[0]) m_slv = 0; if (d[1]) m_rserr = 0; end
                A_ERRC: m_errc = d[0];
                default: ;
            endcase
        end
        if (good) begin
            m_cnt--;
            if (m_cnt < 4) m_qcnt = m_cnt;
            if (!m_ctrl[9] && m_ctrl[5] && m_cnt <= 3) m_generate();
        end
        e_gen = n_gen; e_rs = n_rs;
    endtask

    task automatic rd(input string tag, input logic [7:0] a);
        step(tag, 1, 0, 2'd2, a, 0);
    endtask

    task automatic wr(input string tag, input logic [7:0] a, input logic [31:0] d);
        step(tag, 1, 1, 2'd2, a, d);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        total++; bad++;
        $display("FAIL R1 watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R9 reset values, on both revisions
        step("R9 ctrl reset", 1, 0, 2'd2, A_CTRL, 0, 1, 32'h0);
        step("R9 cfg2 reset", 1, 0, 2'd2, A_CFG2, 0, 1, 32'h210C);
        step("R9 cfg3 reset", 1, 0, 2'd2, A_CFG3, 0, 1, 32'h26F09);
        rd("R9 hold reset", A_HOLD);
        rd("R9 status reset", A_STAT);
        // R3 marker while held, then while empty
        rd("R3 read while held", A_DATA);
        wr("R7 release hold", A_HOLD, 0);
        rd("R3 read while empty", A_DATA);
        // R5 and R6: single-mode generate with empty budget
        wr("R5 generate single", A_CTRL, 32'h2A0);
        rd("R1 status after generate", A_STAT);
        rd("R6 budget error flag", A_FLAG);
        wr("R6 clear budget flag", A_FLAG, 32'h2);
        rd("R6 flag cleared", A_FLAG);
        // R2 drain all eight words; no refill in single mode
        for (int i = 0; i < 8; i++) begin
            rd("R2 data read", A_DATA);
            rd("R2 qcnt follows", A_STAT);
        end
        rd("R3 underflow", A_DATA);
        rd("R3 count unchanged", A_STAT);
        wr("R5 clear done", A_STAT, 32'h1);
        rd("R5 done cleared", A_STAT);
        // R4 continuous mode refills at three or fewer words
        wr("R4 generate continuous", A_CTRL, 32'hA0);
        for (int i = 0; i < 12; i++) begin
            rd("R4 data read", A_DATA);
            rd("R4 status", A_STAT);
        end
        rd("R6 auto reseed flag", A_FLAG);
        // R5 explicit reseed empties the queue
        wr("R5 reseed", A_CTRL, 32'h20);
        rd("R5 read after reseed", A_DATA);
        rd("R5 status after reseed", A_STAT);
        // R7 soft reset clears status
        wr("R5 generate again", A_CTRL, 32'h2A0);
        wr("R7 soft reset", A_CTRL, 32'h1);
        rd("R7 status cleared", A_STAT);
        rd("R3 read in soft reset", A_DATA);
        wr("R7 leave soft reset", A_CTRL, 32'h0);
        wr("R7 generate", A_CTRL, 32'h2A0);
        wr("R7 hold rising", A_HOLD, 32'h1);
        rd("R7 status after hold", A_STAT);
        wr("R7 ctrl while held", A_CTRL, 32'h2A0);
        rd("R7 no action while held", A_STAT);
        wr("R7 release", A_HOLD, 0);
        // R10 bad sizes
        step("R10 byte write", 1, 1, 2'd0, A_CTRL, 32'hA0);
        rd("R10 ctrl unchanged", A_CTRL);
        rd("R10 no flag when disabled", A_FLAG);
        wr("R10 enable reporting", A_ERRC, 32'h1);
        step("R10 half read", 1, 0, 2'd1, A_STAT, 0);
        step("R10 rsvd write", 1, 1, 2'd3, A_HOLD, 32'h1);
        rd("R10 hold unchanged", A_HOLD);
        rd("R10 flag set", A_FLAG);
        wr("R10 clear flag", A_FLAG, 32'h1);
        rd("R10 flag cleared", A_FLAG);
        // R8 revision masking
        wr("R8 ctrl all ones", A_CTRL, 32'hFFFF_FFFF);
        step("R8 ctrl masked", 1, 0, 2'd2, A_CTRL, 0, 1, 32'hFFFF_F9FF);
        wr("R8 cfg2 write", A_CFG2, 32'h1234);
        step("R8 cfg2 readback", 1, 0, 2'd2, A_CFG2, 0, 1, 32'h210C);
        wr("R8 cfg4 write", A_CFG4, 32'h1);
        step("R8 cfg4 readback", 1, 0, 2'd2, A_CFG4, 0, 1, 32'h0);
        wr("R8 ctrl clear", A_CTRL, 32'h0);
        step("R9 idle", 0, 0, 2'd2, 8'h00, 0);
        step("R9 idle", 0, 0, 2'd2, 8'h00, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule